// File: doc/BRIEF.md
# External interrupt pin controller

This block watches up to eight asynchronous interrupt pins from outside the chip and turns them into pending flags. It also raises an interrupt request toward a parent interrupt controller. Each pin first passes through a two-flop synchroniser. A per-pin detection mode then selects one of five event types: a rising edge, a falling edge, both edges, a high level or a low level. An edge event is held in a pending flag until software clears it. In a level mode the pending flag follows the pin.

Software reaches five registers over a plain single-cycle register bus. Two 32-bit registers hold the per-pin fields: one for the detection mode and one for a 4-bit priority. A source register reads back the pending flags, and a zero written to a bit position clears that flag. Two write-only registers set and clear the per-pin mask. A pin raises its own request line only when three conditions hold: it is pending, it is unmasked, and its priority field is nonzero. The combined request is the OR of all the per-pin lines.

Top module: `extpin_irqctl`

## Requirements
- R1: After reset, every pin is masked, the priority and mode registers read 0, the source register reads 0, and `irqOut` and `pinIrq` are low.
- R2: Each pin is synchronised through two flops. A pin change presented before a rising clock edge shows up in the pending flag after the third rising edge and not before.
- R3: The mode field of pin n is SENSE_W bits wide, sits at bit 32-(n+1)*SENSE_W of register 0, and is placed so that pin 0 takes the top bits. The codes are 0 = falling edge, 1 = rising edge, 2 = low level, 3 = high level and 4 = both edges. Any other code detects nothing.
- R4: In an edge mode the pending flag stays set after the pin returns to its idle level, until software clears it.
- R5: Pin k maps to bit FLAG_W-1-k of the source, mask-set and mask-clear registers. Writing the source register (address 2) clears the flag of every bit written 0 and leaves the flag of every bit written 1. An edge event in the same cycle as a clear leaves the flag set.
- R6: In a level mode the pending flag follows the synchronised pin, set while the selected level is present and cleared when it goes away. A clear write while the level is still present leaves the flag set.
- R7: Writing 1 to a bit of the mask-set register (address 3) masks that pin. Writing 1 to a bit of the mask-clear register (address 4) unmasks it. A 0 bit changes nothing, and both registers read 0.
- R8: Register 1 holds a 4-bit priority for pin n at bit 28-4n. A zero field blocks the pin's request without touching its pending flag, and a nonzero field lets the request through.
- R9: `pinIrq[k]` is high exactly when pin k is pending, unmasked and has a nonzero priority. `irqOut` is high when any `pinIrq` bit is high.
- R10: Reads are combinational. The mode and priority registers read back all 32 bits. The source register reads the flags with the upper bits zero, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extPins | input | NUM_PINS | Asynchronous external interrupt pins |
| regWrite | input | 1 | Write strobe for the addressed register |
| regAddr | input | 3 | Register address (0 mode, 1 priority, 2 source, 3 mask-set, 4 mask-clear) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` |
| pinIrq | output | NUM_PINS | Per-pin request lines, bit k for pin k |
| irqOut | output | 1 | Combined request to the parent controller |

## Verification
The hardest case to reach from the ports is an edge event that lands in exactly the same clock cycle as a software clear of that same flag. The bench counts the three-edge synchroniser latency. It starts the clear write one cycle after it has seen no flag yet, so that the write strobe and the detected edge meet at the same register edge. The level-mode case, where a clear write is issued while the level is still present, is driven in the same way and then read back through the source register.

// File: rtl/extpin_pkg.sv
package extpin_pkg;

  // Register addresses on the bus
  localparam logic [2:0] ADDR_SENSE  = 3'd0;
  localparam logic [2:0] ADDR_PRIO   = 3'd1;
  localparam logic [2:0] ADDR_SOURCE = 3'd2;
  localparam logic [2:0] ADDR_MSET   = 3'd3;
  localparam logic [2:0] ADDR_MCLR   = 3'd4;

  // Detection mode codes (4-bit view of a mode field)
  localparam logic [3:0] MODE_FALL = 4'd0;
  localparam logic [3:0] MODE_RISE = 4'd1;
  localparam logic [3:0] MODE_LOW  = 4'd2;
  localparam logic [3:0] MODE_HIGH = 4'd3;
  localparam logic [3:0] MODE_BOTH = 4'd4;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_SENSE  = 2'd1,
    RD_PRIO   = 2'd2,
    RD_SOURCE = 2'd3
  } rdSelE;

  typedef struct packed {
    logic  wrSense;
    logic  wrPrio;
    logic  wrSource;
    logic  wrMaskSet;
    logic  wrMaskClr;
    rdSelE rdSel;
  } strobeS;

endpackage

// File: rtl/extpin_decode.sv
module extpin_decode
  import extpin_pkg::*;
(
  input  logic       regWrite,
  input  logic [2:0] regAddr,
  output strobeS     strb
);

  always_comb begin
    strb           = '0;
    strb.rdSel     = RD_ZERO;
    strb.wrSense   = regWrite && (regAddr == ADDR_SENSE);
    strb.wrPrio    = regWrite && (regAddr == ADDR_PRIO);
    strb.wrSource  = regWrite && (regAddr == ADDR_SOURCE);
    strb.wrMaskSet = regWrite && (regAddr == ADDR_MSET);
    strb.wrMaskClr = regWrite && (regAddr == ADDR_MCLR);
    unique case (regAddr)
      ADDR_SENSE:  strb.rdSel = RD_SENSE;
      ADDR_PRIO:   strb.rdSel = RD_PRIO;
      ADDR_SOURCE: strb.rdSel = RD_SOURCE;
      default:     strb.rdSel = RD_ZERO;  // write-only and unused addresses
    endcase
  end

endmodule

// File: rtl/extpin_core.sv
module extpin_core
  import extpin_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int FLAG_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] extPins,
  input  strobeS              strb,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [NUM_PINS-1:0] pinIrq,
  output logic                irqOut
);

  localparam int PRIO_W = 4;

  logic [NUM_PINS-1:0] syncA, syncB, prevB;
  logic [NUM_PINS-1:0] pendReg, maskReg;
  logic [31:0]         senseReg, prioReg;
  logic [FLAG_W-1:0]   srcVec;

  // Two-flop synchroniser plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= extPins;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseReg <= '0;
      prioReg  <= '0;
    end else begin
      if (strb.wrSense) senseReg <= wdata;
      if (strb.wrPrio)  prioReg  <= wdata;
    end
  end

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    localparam int MODE_LO = 32 - (k + 1) * SENSE_W;
    localparam int PRIO_LO = 32 - (k + 1) * PRIO_W;
    localparam int FLAG_B  = FLAG_W - 1 - k;

    logic [3:0] modeCode;
    logic       edgeHit, levelMode, levelAct, clrHit;

    assign modeCode = 4'(senseReg[MODE_LO +: SENSE_W]);

    always_comb begin
      edgeHit   = 1'b0;
      levelMode = 1'b0;
      levelAct  = 1'b0;
      case (modeCode)
        MODE_FALL: edgeHit = prevB[k] & ~syncB[k];
        MODE_RISE: edgeHit = ~prevB[k] & syncB[k];
        MODE_BOTH: edgeHit = prevB[k] ^ syncB[k];
        MODE_LOW:  begin levelMode = 1'b1; levelAct = ~syncB[k]; end
        MODE_HIGH: begin levelMode = 1'b1; levelAct = syncB[k];  end
        default:   edgeHit = 1'b0;  // undefined codes detect nothing
      endcase
    end

    assign clrHit = strb.wrSource && !wdata[FLAG_B];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendReg[k] <= 1'b0;
        maskReg[k] <= 1'b1;
      end else begin
        if (levelMode) pendReg[k] <= levelAct;
        else           pendReg[k] <= edgeHit | (pendReg[k] & ~clrHit);
        if (strb.wrMaskSet && wdata[FLAG_B])      maskReg[k] <= 1'b1;
        else if (strb.wrMaskClr && wdata[FLAG_B]) maskReg[k] <= 1'b0;
      end
    end

    assign pinIrq[k] = pendReg[k] & ~maskReg[k] & (|prioReg[PRIO_LO +: PRIO_W]);
  end

  assign irqOut = |pinIrq;

  always_comb begin
    srcVec = '0;
    for (int k = 0; k < NUM_PINS; k++) srcVec[FLAG_W-1-k] = pendReg[k];
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_SENSE:  rdata = senseReg;
      RD_PRIO:   rdata = prioReg;
      RD_SOURCE: rdata = 32'(srcVec);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/extpin_irqctl.sv
module extpin_irqctl
  import extpin_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int FLAG_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] extPins,
  input  logic                regWrite,
  input  logic [2:0]          regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  output logic [NUM_PINS-1:0] pinIrq,
  output logic                irqOut
);

  strobeS strb;

  extpin_decode u_decode (
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strb     (strb)
  );

  extpin_core #(
    .NUM_PINS (NUM_PINS),
    .SENSE_W  (SENSE_W),
    .FLAG_W   (FLAG_W)
  ) u_core (
    .clk     (clk),
    .rstN    (rstN),
    .extPins (extPins),
    .strb    (strb),
    .wdata   (regWdata),
    .rdata   (regRdata),
    .pinIrq  (pinIrq),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/extpin_irqctl_chk.sv
module extpin_irqctl_chk #(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int FLAG_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] extPins,
  input logic                regWrite,
  input logic [2:0]          regAddr,
  input logic [31:0]         regWdata,
  input logic [31:0]         regRdata,
  input logic [NUM_PINS-1:0] pinIrq,
  input logic                irqOut
);

  // R1: while reset is held, no request leaves the block
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (!irqOut && pinIrq == '0));

  // R7: masking every pin silences every request line on the next cycle
  p_mask_all_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == 3'd3 && (&regWdata[FLAG_W-1 -: NUM_PINS]))
    |=> (pinIrq == '0 && !irqOut));

  // R7: write-only mask registers read zero
  p_wo_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd3 || regAddr == 3'd4) |-> (regRdata == 32'd0));

  // R8: an all-zero priority register blocks every pin on the next cycle
  p_prio_zero_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == 3'd1 && regWdata == 32'd0) |=> (pinIrq == '0));

  // R10: unused addresses read zero
  p_unused_read_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > 3'd4) |-> (regRdata == 32'd0));

endmodule

bind extpin_irqctl extpin_irqctl_chk #(
  .NUM_PINS (NUM_PINS),
  .SENSE_W  (SENSE_W),
  .FLAG_W   (FLAG_W)
) u_chk (.*);

// File: tb/extpin_irqctl_bench.sv
module extpin_irqctl_bench;

  localparam int NUM_PINS = 8;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [NUM_PINS-1:0] extPins = 8'h04;
  logic                regWrite = 1'b0;
  logic [2:0]          regAddr = 3'd0;
  logic [31:0]         regWdata = 32'd0;
  logic [31:0]         regRdata;
  logic [NUM_PINS-1:0] pinIrq;
  logic                irqOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  typedef struct packed {
    logic [31:0]         expRd;
    logic [NUM_PINS-1:0] expPin;
    logic                expIrq;
  } itemS;

  itemS  expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  extpin_irqctl #(.NUM_PINS(NUM_PINS), .SENSE_W(4), .FLAG_W(8)) u_extpin_irqctl (
    .clk      (clk),
    .rstN     (rstN),
    .extPins  (extPins),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .pinIrq   (pinIrq),
    .irqOut   (irqOut)
  );

  // Monitor: compares outputs against queued expectations away from the edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      itemS  it;
      string tg;
      it = expQ.pop_front();
      tg = tagQ.pop_front();
      nChecks++;
      if (regRdata !== it.expRd || pinIrq !== it.expPin || irqOut !== it.expIrq) begin
        nFails++;
        $display("FAIL %s: rdata=%h pinIrq=%h irq=%b expected rdata=%h pinIrq=%h irq=%b",
                 tg, regRdata, pinIrq, irqOut, it.expRd, it.expPin, it.expIrq);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrite = 1'b1;
    regAddr  = a;
    regWdata = d;
    tick(1);
    regWrite = 1'b0;
  endtask

  // Driver: queues an expectation and lets the monitor compare it
  task automatic expect_out(input logic [2:0] a, input logic [31:0] rd,
                            input logic [NUM_PINS-1:0] pins, input logic irq,
                            input string tg);
    itemS it;
    regAddr   = a;
    it.expRd  = rd;
    it.expPin = pins;
    it.expIrq = irq;
    expQ.push_back(it);
    tagQ.push_back(tg);
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    // Reset state
    expect_out(3'd2, 32'h0, 8'h00, 1'b0, "R1 source after reset");
    expect_out(3'd1, 32'h0, 8'h00, 1'b0, "R1 priority after reset");
    expect_out(3'd0, 32'h0, 8'h00, 1'b0, "R1 mode after reset");

    // Modes: p0 rise, p1 fall, p2 low, p3 high, p4 both, p5 code 7, p6 rise, p7 rise
    wr(3'd0, 32'h10234711);
    expect_out(3'd0, 32'h10234711, 8'h00, 1'b0, "R10 mode readback");
    wr(3'd1, 32'hFFFFFFFF);
    wr(3'd4, 32'h000000FF);
    expect_out(3'd1, 32'hFFFFFFFF, 8'h00, 1'b0, "R8 priority readback");
    expect_out(3'd2, 32'h0, 8'h00, 1'b0, "R7 unmasked with nothing pending");

    // Rising edge on pin 0 and the synchroniser latency
    extPins[0] = 1'b1;
    tick(2);
    expect_out(3'd2, 32'h0, 8'h00, 1'b0, "R2 no flag before third edge");
    tick(1);
    expect_out(3'd2, 32'h80, 8'h01, 1'b1, "R2 flag after third edge");

    extPins[0] = 1'b0;
    tick(4);
    expect_out(3'd2, 32'h80, 8'h01, 1'b1, "R4 edge flag held");

    wr(3'd2, 32'hFF);
    expect_out(3'd2, 32'h80, 8'h01, 1'b1, "R5 ones leave flag");
    wr(3'd2, 32'h7F);
    expect_out(3'd2, 32'h00, 8'h00, 1'b0, "R5 zero clears pin 0");

    // Falling edge on pin 1
    extPins[1] = 1'b1;
    tick(4);
    expect_out(3'd2, 32'h00, 8'h00, 1'b0, "R3 falling mode ignores rise");
    extPins[1] = 1'b0;
    tick(3);
    expect_out(3'd2, 32'h40, 8'h02, 1'b1, "R3 falling edge on pin 1");

    // Mask set/clear
    wr(3'd3, 32'h40);
    expect_out(3'd2, 32'h40, 8'h00, 1'b0, "R7 mask-set blocks pin 1");
    expect_out(3'd3, 32'h0, 8'h00, 1'b0, "R7 mask-set reads zero");
    expect_out(3'd4, 32'h0, 8'h00, 1'b0, "R7 mask-clear reads zero");
    wr(3'd4, 32'hBF);
    expect_out(3'd2, 32'h40, 8'h00, 1'b0, "R7 zero bit does not unmask");
    wr(3'd4, 32'h40);
    expect_out(3'd2, 32'h40, 8'h02, 1'b1, "R7 mask-clear unmasks pin 1");
    wr(3'd2, 32'hBF);
    expect_out(3'd2, 32'h00, 8'h00, 1'b0, "R5 clear pin 1");

    // Low level on pin 2
    extPins[2] = 1'b0;
    tick(3);
    expect_out(3'd2, 32'h20, 8'h04, 1'b1, "R6 low level sets flag");
    wr(3'd2, 32'hDF);
    expect_out(3'd2, 32'h20, 8'h04, 1'b1, "R6 clear ignored while level active");
    extPins[2] = 1'b1;
    tick(3);
    expect_out(3'd2, 32'h00, 8'h00, 1'b0, "R6 flag follows level away");

    // High level on pin 3
    extPins[3] = 1'b1;
    tick(3);
    expect_out(3'd2, 32'h10, 8'h08, 1'b1, "R6 high level sets flag");
    extPins[3] = 1'b0;
    tick(3);
    expect_out(3'd2, 32'h00, 8'h00, 1'b0, "R6 high level released");

    // Both edges on pin 4
    extPins[4] = 1'b1;
    tick(3);
    expect_out(3'd2, 32'h08, 8'h10, 1'b1, "R3 both-edge rise");
    wr(3'd2, 32'hF7);
    extPins[4] = 1'b0;
    tick(3);
    expect_out(3'd2, 32'h08, 8'h10, 1'b1, "R3 both-edge fall");
    wr(3'd2, 32'hF7);

    // Undefined code on pin 5
    extPins[5] = 1'b1;
    tick(4);
    extPins[5] = 1'b0;
    tick(4);
    expect_out(3'd2, 32'h00, 8'h00, 1'b0, "R3 undefined code detects nothing");

    // Zero priority on pin 6
    wr(3'd1, 32'hFFFFFF0F);
    extPins[6] = 1'b1;
    tick(3);
    expect_out(3'd2, 32'h02, 8'h00, 1'b0, "R8 zero priority blocks pin 6");
    wr(3'd1, 32'hFFFFFFFF);
    expect_out(3'd2, 32'h02, 8'h40, 1'b1, "R9 priority restored passes pin 6");
    wr(3'd2, 32'hFD);

    // Edge and clear in the same cycle on pin 7
    extPins[7] = 1'b1;
    tick(2);
    wr(3'd2, 32'hFE);
    expect_out(3'd2, 32'h01, 8'h80, 1'b1, "R5 edge wins over same-cycle clear");
    wr(3'd2, 32'hFE);
    expect_out(3'd2, 32'h00, 8'h00, 1'b0, "R5 later clear works");

    expect_out(3'd5, 32'h0, 8'h00, 1'b0, "R10 unused address reads zero");

    // Two pins at once
    extPins[0] = 1'b1;
    extPins[4] = 1'b1;
    tick(3);
    expect_out(3'd2, 32'h88, 8'h11, 1'b1, "R9 two pins pending");
    wr(3'd3, 32'hFF);
    expect_out(3'd2, 32'h88, 8'h00, 1'b0, "R9 all masked drops irqOut");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule